// File: doc/BRIEF.md
# Vectored Seven-Level Interrupt Handler

This block sits on the handler side of a shared backplane that carries seven active-low interrupt request lines, numbered 1 to 7. Each line first passes through a two-flop synchronizer. The block then masks the lines with a per-level enable vector and picks the highest enabled level that is pending. It reports that level to a local processor as a pending flag and a 3-bit level code.

When the processor pulses its acknowledge input, the handler runs an interrupt-acknowledge bus cycle. It asserts the bus acknowledge line and the address strobe, and it drives the level it has taken on a 3-bit address field. It then asserts the data strobe and waits for the interrupter's answer. A data acknowledge captures the 8-bit status/ID vector from the data lines, and the processor can jump straight to the matching service routine. A bus error ends the cycle with a spurious flag and no vector. The strobes are released, and the handler returns to idle only once the responder has withdrawn its answer.

Top module: `irq_vector_handler`

## Requirements
- R1: While reset is held and after it is released, the bus acknowledge, address strobe and data strobe outputs are high (inactive), pending is 0, the level code is 0, done is 0 and spurious is 0.
- R2: The level code is the binary number (1 to 7) of the highest pending enabled request, where input bit i is level i+1 and level 7 wins. Pending is 1 exactly when the code is non-zero. With nothing pending the code is 0.
- R3: A request whose enable bit (bit i for level i+1) is 0 is never reported. A lower enabled request that is pending stays reported and waiting until it is served.
- R4: A change on a request input shows in the level code after exactly two rising clock edges, and not after one.
- R5: An acknowledge pulse taken while pending and idle makes the bus acknowledge and address strobe go low after the next edge, with the taken level on the address field and the data strobe still high. The data strobe goes low one edge later.
- R6: While the data strobe is low, the handler waits for any number of cycles. A low data acknowledge captures the data lines into the vector output, raises done for exactly one cycle and clears spurious.
- R7: A low bus error seen while the data strobe is low ends the cycle instead. Done pulses, spurious is set to 1 and the vector output is 0.
- R8: After the answer is captured, both strobes go high at once. The bus acknowledge stays low until data acknowledge and bus error are both high, and it goes high one edge after that.
- R9: An acknowledge pulse while nothing is pending starts no bus cycle.
- R10: The address field holds the taken level for the whole cycle, even when the request inputs change during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irqReqN | input | 7 | Active-low request lines, bit i is level i+1 |
| levelEnable | input | 7 | Per-level enable, bit i is level i+1 |
| cpuAck | input | 1 | Processor acknowledge pulse |
| cpuIrqPending | output | 1 | An enabled level is pending |
| cpuIrqLevel | output | 3 | Highest pending enabled level, 0 when none |
| cpuVector | output | 8 | Last status/ID vector taken (0 after a bus error) |
| cpuDone | output | 1 | One-cycle pulse when an acknowledge cycle has its answer |
| cpuSpurious | output | 1 | Last acknowledge cycle ended in a bus error |
| busAckN | output | 1 | Active-low interrupt acknowledge |
| busAsN | output | 1 | Active-low address strobe |
| busDsN | output | 1 | Active-low data strobe |
| busAddr | output | 3 | Level code driven during the acknowledge cycle |
| busData | input | 8 | Low data lines carrying the vector |
| busDtackN | input | 1 | Active-low data acknowledge |
| busBerrN | input | 1 | Active-low bus error |

## Verification
The assertions check on every cycle that done is a single-cycle pulse that follows a strobed answer, that a reported level is always enabled, and that a spurious answer carries a zero vector. They also check that the address field holds still while acknowledge is low, that a bus cycle only starts from a pending acknowledge, and that the release phase waits for the responder. Only the bench scenarios show the order in which a full set of requests is drained, the two-edge synchronizer latency, and the priority result over every combination of request and enable. They also show the exact edges of the strobe sequence with several wait lengths, and that an acknowledge with nothing pending is ignored.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  typedef struct packed {
    logic captureLevel;
    logic captureVector;
    logic flagSpurious;
  } vih_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ADDR    = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RELEASE = 2'd3
  } vih_state_t;

endpackage

// File: rtl/irq_vector_datapath.sv
module irq_vector_datapath
  import irq_vector_pkg::*;
#(
  parameter int LEVELS      = 7,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVELS-1:0]  irqReqN,
  input  logic [LEVELS-1:0]  levelEnable,
  input  vih_strobe_t        strobes,
  input  logic [VEC_W-1:0]   busData,
  output logic               cpuIrqPending,
  output logic [LVL_W-1:0]   cpuIrqLevel,
  output logic [VEC_W-1:0]   cpuVector,
  output logic               cpuDone,
  output logic               cpuSpurious,
  output logic [LVL_W-1:0]   busAddr
);

  // synchronizer chain, inactive (high) at reset
  logic [LEVELS-1:0] syncStage [SYNC_STAGES];

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          syncStage[s] <= '1;
        end else if (s == 0) begin
          syncStage[s] <= irqReqN;
        end else begin
          syncStage[s] <= syncStage[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  logic [LEVELS-1:0] reqActive;
  logic [LEVELS-1:0] reqMasked;
  logic [LVL_W-1:0]  bestLevel;

  assign reqActive = ~syncStage[SYNC_STAGES-1];
  assign reqMasked = reqActive & levelEnable;

  // ascending scan so the highest set bit wins
  always_comb begin
    bestLevel = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (reqMasked[i]) bestLevel = LVL_W'(i + 1);
    end
  end

  assign cpuIrqLevel   = bestLevel;
  assign cpuIrqPending = |reqMasked;

  logic [LVL_W-1:0] takenLevel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      takenLevel  <= '0;
      cpuVector   <= '0;
      cpuDone     <= 1'b0;
      cpuSpurious <= 1'b0;
    end else begin
      cpuDone <= strobes.captureVector | strobes.flagSpurious;
      if (strobes.captureLevel) takenLevel <= bestLevel;
      if (strobes.captureVector) begin
        cpuVector   <= busData;
        cpuSpurious <= 1'b0;
      end else if (strobes.flagSpurious) begin
        cpuVector   <= '0;
        cpuSpurious <= 1'b1;
      end
    end
  end

  assign busAddr = takenLevel;

  logic [LEVELS:0] enableExt;
  assign enableExt = {levelEnable, 1'b0};

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpuDone |=> !cpuDone);

  a_r3_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    cpuIrqPending |-> enableExt[cpuIrqLevel]);

  a_r7_spurious_zero_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuDone && cpuSpurious) |-> (cpuVector == '0));

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpuAck,
  input  logic        cpuIrqPending,
  input  logic        busDtackN,
  input  logic        busBerrN,
  output vih_strobe_t strobes,
  output logic        busAckN,
  output logic        busAsN,
  output logic        busDsN
);

  vih_state_t state, stateNext;
  logic answerSeen;

  assign answerSeen = !busDtackN || !busBerrN;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (cpuAck && cpuIrqPending) begin
          strobes.captureLevel = 1'b1;
          stateNext = ST_ADDR;
        end
      end
      ST_ADDR: stateNext = ST_STROBE;
      ST_STROBE: begin
        if (!busDtackN) begin
          strobes.captureVector = 1'b1;
          stateNext = ST_RELEASE;
        end else if (!busBerrN) begin
          strobes.flagSpurious = 1'b1;
          stateNext = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (!answerSeen) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busAckN = (state == ST_IDLE);
  assign busAsN  = !((state == ST_ADDR) || (state == ST_STROBE));
  assign busDsN  = (state != ST_STROBE);

  a_r8_release_waits: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RELEASE) && answerSeen) |=> (state == ST_RELEASE));

endmodule

// File: rtl/irq_vector_handler.sv
module irq_vector_handler
  import irq_vector_pkg::*;
#(
  parameter int LEVELS      = 7,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irqReqN,
  input  logic [LEVELS-1:0] levelEnable,
  input  logic              cpuAck,
  output logic              cpuIrqPending,
  output logic [LVL_W-1:0]  cpuIrqLevel,
  output logic [VEC_W-1:0]  cpuVector,
  output logic              cpuDone,
  output logic              cpuSpurious,
  output logic              busAckN,
  output logic              busAsN,
  output logic              busDsN,
  output logic [LVL_W-1:0]  busAddr,
  input  logic [VEC_W-1:0]  busData,
  input  logic              busDtackN,
  input  logic              busBerrN
);

  vih_strobe_t strobes;

  irq_vector_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpuAck       (cpuAck),
    .cpuIrqPending(cpuIrqPending),
    .busDtackN    (busDtackN),
    .busBerrN     (busBerrN),
    .strobes      (strobes),
    .busAckN      (busAckN),
    .busAsN       (busAsN),
    .busDsN       (busDsN)
  );

  irq_vector_datapath #(
    .LEVELS     (LEVELS),
    .VEC_W      (VEC_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irqReqN      (irqReqN),
    .levelEnable  (levelEnable),
    .strobes      (strobes),
    .busData      (busData),
    .cpuIrqPending(cpuIrqPending),
    .cpuIrqLevel  (cpuIrqLevel),
    .cpuVector    (cpuVector),
    .cpuDone      (cpuDone),
    .cpuSpurious  (cpuSpurious),
    .busAddr      (busAddr)
  );

  a_r6_done_after_answer: assert property (@(posedge clk) disable iff (!rst_n)
    cpuDone |-> $past(!busDsN && (!busDtackN || !busBerrN)));

  a_r9_cycle_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busAckN) |-> $past(cpuAck && cpuIrqPending));

  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busAckN && $past(!busAckN)) |-> $stable(busAddr));

endmodule

// File: tb/irq_vector_handler_tb_top.sv
module irq_vector_handler_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irqReqN = 7'h7F;
  logic [6:0] levelEnable = 7'h7F;
  logic       cpuAck = 1'b0;
  logic       cpuIrqPending;
  logic [2:0] cpuIrqLevel;
  logic [7:0] cpuVector;
  logic       cpuDone;
  logic       cpuSpurious;
  logic       busAckN, busAsN, busDsN;
  logic [2:0] busAddr;
  logic [7:0] busData = 8'h00;
  logic       busDtackN = 1'b1;
  logic       busBerrN = 1'b1;

  int checks = 0;
  int fails  = 0;
  int reqMask = 0;

  always #5 clk = ~clk;

  irq_vector_handler dut_i (
    .clk(clk), .rst_n(rst_n), .irqReqN(irqReqN), .levelEnable(levelEnable),
    .cpuAck(cpuAck), .cpuIrqPending(cpuIrqPending), .cpuIrqLevel(cpuIrqLevel),
    .cpuVector(cpuVector), .cpuDone(cpuDone), .cpuSpurious(cpuSpurious),
    .busAckN(busAckN), .busAsN(busAsN), .busDsN(busDsN), .busAddr(busAddr),
    .busData(busData), .busDtackN(busDtackN), .busBerrN(busBerrN)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLevel(input int req, input int en);
    for (int i = 7; i >= 1; i--) if ((((req & en) >> (i - 1)) & 1) != 0) return i;
    return 0;
  endfunction

  function automatic int vecFor(input int lvl);
    return (8'h80 ^ (lvl * 17)) & 8'hFF;
  endfunction

  task automatic setReq(input int m);
    reqMask = m;
    irqReqN = ~7'(m);
  endtask

  // full acknowledge cycle for the currently reported level
  task automatic ackCycle(input int lvl, input bit useBerr, input int waitCyc);
    int nextExp;
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
    chk("R5 ack low", busAckN, 0);
    chk("R5 as low", busAsN, 0);
    chk("R5 ds high", busDsN, 1);
    chk("R5 addr level", busAddr, lvl);
    @(negedge clk);
    chk("R5 ds low", busDsN, 0);
    setReq(reqMask & ~(1 << (lvl - 1)));
    nextExp = expLevel(reqMask, levelEnable);
    for (int w = 0; w < waitCyc; w++) begin
      @(negedge clk);
      chk("R6 wait ds", busDsN, 0);
      chk("R6 wait done", cpuDone, 0);
    end
    if (useBerr) busBerrN = 1'b0;
    else begin busDtackN = 1'b0; busData = 8'(vecFor(lvl)); end
    @(negedge clk);
    chk("R6 done pulse", cpuDone, 1);
    if (useBerr) begin
      chk("R7 spurious", cpuSpurious, 1);
      chk("R7 vector zero", cpuVector, 0);
    end else begin
      chk("R6 spurious clear", cpuSpurious, 0);
      chk("R6 vector", cpuVector, vecFor(lvl));
    end
    chk("R8 ds release", busDsN, 1);
    chk("R8 as release", busAsN, 1);
    chk("R8 ack held", busAckN, 0);
    @(negedge clk);
    chk("R6 done single", cpuDone, 0);
    chk("R8 ack still held", busAckN, 0);
    chk("R10 addr held", busAddr, lvl);
    chk("R3 next level", cpuIrqLevel, nextExp);
    busDtackN = 1'b1;
    busBerrN  = 1'b1;
    @(negedge clk);
    chk("R8 ack idle", busAckN, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ack in reset", busAckN, 1);
    chk("R1 pending in reset", cpuIrqPending, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack", busAckN, 1);
    chk("R1 as", busAsN, 1);
    chk("R1 ds", busDsN, 1);
    chk("R1 pending", cpuIrqPending, 0);
    chk("R1 level", cpuIrqLevel, 0);
    chk("R1 done", cpuDone, 0);
    chk("R1 spurious", cpuSpurious, 0);

    // R9: acknowledge with nothing pending
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
    chk("R9 no cycle", busAckN, 1);
    @(negedge clk);
    chk("R9 no strobe", busAsN, 1);

    // R2/R3: every request pattern against every enable mask
    for (int en = 0; en < 128; en++) begin
      for (int rq = 0; rq < 128; rq++) begin
        levelEnable = 7'(en);
        setReq(rq);
        repeat (3) @(negedge clk);
        chk("R2 level", cpuIrqLevel, expLevel(rq, en));
        chk("R2 pending", cpuIrqPending, int'(expLevel(rq, en) != 0));
      end
    end

    // R4: two-edge latency
    levelEnable = 7'h7F;
    setReq(0);
    repeat (3) @(negedge clk);
    for (int l = 1; l <= 7; l++) begin
      setReq(1 << (l - 1));
      @(negedge clk);
      chk("R4 not after one edge", cpuIrqLevel, 0);
      @(negedge clk);
      chk("R4 after two edges", cpuIrqLevel, l);
      setReq(0);
      repeat (3) @(negedge clk);
    end

    // R6/R7/R8/R10: drain all seven levels in order, level 3 answers with an error
    setReq(7'h7F);
    repeat (3) @(negedge clk);
    for (int l = 7; l >= 1; l--) begin
      chk("R2 drain level", cpuIrqLevel, l);
      ackCycle(l, l == 3, l % 3);
      repeat (2) @(negedge clk);
    end
    chk("R2 drained", cpuIrqPending, 0);

    // R3: masked level stays hidden while a lower one is served
    levelEnable = 7'b1101111;
    setReq((1 << 4) | (1 << 1));
    repeat (3) @(negedge clk);
    chk("R3 masked hidden", cpuIrqLevel, 2);
    ackCycle(2, 1'b0, 0);
    repeat (2) @(negedge clk);
    chk("R3 masked not pending", cpuIrqPending, 0);
    levelEnable = 7'h7F;
    @(negedge clk);
    chk("R3 enabled shows", cpuIrqLevel, 5);
    ackCycle(5, 1'b0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule